// File: doc/BRIEF.md
# Eight-Line GPIO Port with Latched Edge Interrupts

This block is a small general-purpose I/O port on a byte-wide register bus with a 3-bit address. By default the low half of its lines drive outputs and the high half sample inputs. Software programs output enables and output values, and reads the levels present on the pins. Each input line passes through a two-flop synchroniser. After that, an edge detector feeds two sticky flags per input: one for rising edges and one for falling edges.

A 2-bit trigger code per input decides which of the two flags appears in the status register. The visible status bits are ORed into one level-sensitive interrupt request. A write of one to a status bit clears both hidden flags of that input, whatever the trigger code is. Because the flags latch regardless of the code, software can clear a pending event and then retarget the edge without losing an edge that lands in between.

Top module: `gpio_edge_port`

## Requirements
- R1: On reset `pad_oe` is 0x0F, `pad_out` is 0x00, the trigger configuration is 0x00, every edge flag is clear and `irq` is low.
- R2: Registers sit at byte addresses 0 (direction), 1 (data), 3 (trigger configuration) and 4 (status). Addresses 2, 5, 6 and 7 read as 0x00, and writes to them change nothing.
- R3: Writing address 0 sets `pad_oe` one clock later. A bit of 1 enables the output driver of that line and 0 leaves it an input. Address 0 reads back the value written.
- R4: Writing address 1 sets `pad_out` one clock later. Reading address 1 returns `pad_in` through the two-flop synchroniser, so a pin change shows after the second rising clock edge. The written value is never returned.
- R5: Input k (k = 0..3, pin k+4) uses trigger bits [2k+1:2k] of address 3. 00 shows nothing, 01 shows the falling flag, 10 shows the rising flag and 11 shows the OR of both flags.
- R6: Each input has a rising flag and a falling flag that are set on every synchronised edge of their kind under any trigger code. A flag is set by the third rising clock edge after the pin change.
- R7: Status bit k (address 4, bits 3:0) shows the flag chosen by input k's trigger code, and bits 7:4 read 0. `irq` is the OR of the four status bits. It stays high until a status write or a configuration write.
- R8: Writing 1 to status bit k clears both flags of input k under any trigger code. Writing 0 leaves them unchanged.
- R9: An edge detected in the same cycle as a clear of its input leaves that flag set.
- R10: An edge latched while its kind is not selected becomes pending, and raises `irq`, as soon as the trigger code selects it.
- R11: Level changes on pins 0 to 3 never set a flag or affect status or `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pad_in | input | 8 | Levels seen on the pins |
| pad_out | output | 8 | Output latch value |
| pad_oe | output | 8 | Output driver enable per line |
| irq | output | 1 | Level interrupt request |

## Verification
On every cycle the assertions check the reset values of the outputs and the one-cycle update of `pad_oe` and `pad_out`. They also check that writes to unused addresses are ignored, that every detected edge lands in its flag, that an all-ones status write with no concurrent edge drops `irq`, and that `irq` holds until a status or configuration write. Other properties need a chosen sequence of stimulus, so only the bench scenarios show them. These are the exact synchroniser latency, the mapping of each trigger code, and a hidden edge surfacing when its code is selected later. The collision of an edge with a clear in the same cycle also falls in this group, along with the rule that the data read returns pin levels rather than the latch.

// File: rtl/gpio_edge_pkg.sv
// Shared definitions for the edge-interrupt GPIO port.
// Assumes a byte-wide bus with a 3-bit address.
package gpio_edge_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] OFF_DIR  = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_DATA = 3'd1;
    localparam logic [ADDR_W-1:0] OFF_CFG  = 3'd3;
    localparam logic [ADDR_W-1:0] OFF_STAT = 3'd4;

    // Per-input trigger selection code
    typedef enum logic [1:0] {
        TRIG_OFF  = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_ANY  = 2'b11
    } trig_e;
endpackage

// File: rtl/gpio_edge_sync.sv
// Two-flop synchroniser for asynchronous pin levels.
// Assumes pins may change at any time relative to clk.
module gpio_edge_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] meta_q;

    // Capture the pins through two flops to settle metastability
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            sync_out <= '0;
        end else begin
            meta_q   <= async_in;
            sync_out <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_edge_flags.sv
// Edge detection, sticky rise/fall flags and status selection.
// Assumes din is already synchronised; a set wins over a clear.
module gpio_edge_flags
    import gpio_edge_pkg::*;
#(
    parameter int NIN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NIN-1:0]   din,
    input  logic [2*NIN-1:0] cfg,
    input  logic [NIN-1:0]   clr,
    output logic [NIN-1:0]   rise_ev,
    output logic [NIN-1:0]   fall_ev,
    output logic [NIN-1:0]   rise_flag,
    output logic [NIN-1:0]   fall_flag,
    output logic [NIN-1:0]   status,
    output logic             irq
);
    logic [NIN-1:0] prev_q;

    assign rise_ev = din & ~prev_q;
    assign fall_ev = ~din & prev_q;

    // Remember the last level and latch edges, with a set beating a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q    <= '0;
            rise_flag <= '0;
            fall_flag <= '0;
        end else begin
            prev_q    <= din;
            rise_flag <= (rise_flag & ~clr) | rise_ev;
            fall_flag <= (fall_flag & ~clr) | fall_ev;
        end
    end

    for (genvar k = 0; k < NIN; k++) begin : g_sel
        // Pick the visible flag for input k from its trigger code
        always_comb begin
            unique case (trig_e'(cfg[2*k +: 2]))
                TRIG_OFF:  status[k] = 1'b0;
                TRIG_FALL: status[k] = fall_flag[k];
                TRIG_RISE: status[k] = rise_flag[k];
                default:   status[k] = rise_flag[k] | fall_flag[k];
            endcase
        end
    end

    assign irq = |status;
endmodule

// File: rtl/gpio_edge_regs.sv
// Writable registers: direction, output latch and trigger configuration.
// Assumes one-cycle write strobes; unknown addresses are ignored.
module gpio_edge_regs
    import gpio_edge_pkg::*;
#(
    parameter int              NLINES  = 8,
    parameter int              NIN     = 4,
    parameter logic [NLINES-1:0] DIR_RST = 8'h0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [NLINES-1:0] wdata,
    output logic [NLINES-1:0] dir_q,
    output logic [NLINES-1:0] out_q,
    output logic [2*NIN-1:0]  cfg_q
);
    // Decode writes into the three stored registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= DIR_RST;
            out_q <= '0;
            cfg_q <= '0;
        end else if (we) begin
            case (addr)
                OFF_DIR:  dir_q <= wdata;
                OFF_DATA: out_q <= wdata;
                OFF_CFG:  cfg_q <= wdata[2*NIN-1:0];
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_edge_port.sv
// Top of the GPIO port: register decode, read mux and edge interrupt path.
// Assumes the upper NLINES-NOUT lines are the edge-sensing inputs.
module gpio_edge_port
    import gpio_edge_pkg::*;
#(
    parameter int NLINES = 8,
    parameter int NOUT   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [NLINES-1:0] bus_wdata,
    output logic [NLINES-1:0] bus_rdata,
    input  logic [NLINES-1:0] pad_in,
    output logic [NLINES-1:0] pad_out,
    output logic [NLINES-1:0] pad_oe,
    output logic              irq
);
    localparam int NIN = NLINES - NOUT;
    localparam logic [NLINES-1:0] DIR_RST = NLINES'((1 << NOUT) - 1);

    logic [NLINES-1:0] pins_s;
    logic [2*NIN-1:0]  cfg_q;
    logic [NIN-1:0]    clr;
    logic [NIN-1:0]    rise_ev, fall_ev, rise_flag, fall_flag, status;

    gpio_edge_sync #(.W(NLINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(pins_s)
    );

    gpio_edge_regs #(.NLINES(NLINES), .NIN(NIN), .DIR_RST(DIR_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we),
        .wdata(bus_wdata), .dir_q(pad_oe), .out_q(pad_out), .cfg_q(cfg_q)
    );

    assign clr = (bus_we && bus_addr == OFF_STAT) ? bus_wdata[NIN-1:0] : '0;

    gpio_edge_flags #(.NIN(NIN)) u_flags (
        .clk(clk), .rst_n(rst_n), .din(pins_s[NLINES-1:NOUT]), .cfg(cfg_q),
        .clr(clr), .rise_ev(rise_ev), .fall_ev(fall_ev),
        .rise_flag(rise_flag), .fall_flag(fall_flag),
        .status(status), .irq(irq)
    );

    // Select read data by address; unmapped addresses return zero
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_DIR:  bus_rdata = pad_oe;
            OFF_DATA: bus_rdata = pins_s;
            OFF_CFG:  bus_rdata[2*NIN-1:0] = cfg_q;
            OFF_STAT: bus_rdata[NIN-1:0] = status;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_edge_chk.sv
// Checker for gpio_edge_port, attached through bind.
// Assumes the default register map from gpio_edge_pkg.
module gpio_edge_chk
    import gpio_edge_pkg::*;
#(
    parameter int NLINES = 8,
    parameter int NOUT   = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic                    bus_we,
    input logic [NLINES-1:0]       bus_wdata,
    input logic [NLINES-1:0]       pad_out,
    input logic [NLINES-1:0]       pad_oe,
    input logic                    irq,
    input logic [NLINES-NOUT-1:0]  rise_ev,
    input logic [NLINES-NOUT-1:0]  fall_ev,
    input logic [NLINES-NOUT-1:0]  rise_flag,
    input logic [NLINES-NOUT-1:0]  fall_flag
);
    localparam int NIN = NLINES - NOUT;

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == NLINES'((1 << NOUT) - 1) && pad_out == '0 && !irq));

    // R2
    unused_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_addr == 3'd2 || bus_addr >= 3'd5)) |=> ($stable(pad_out) && $stable(pad_oe)));

    // R3
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFF_DIR) |=> pad_oe == $past(bus_wdata));

    // R4
    data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFF_DATA) |=> pad_out == $past(bus_wdata));

    // R6
    rise_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_ev != '0) |=> ((rise_flag & $past(rise_ev)) == $past(rise_ev)));

    // R6
    fall_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_ev != '0) |=> ((fall_flag & $past(fall_ev)) == $past(fall_ev)));

    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(bus_we && (bus_addr == OFF_STAT || bus_addr == OFF_CFG))) |=> irq);

    // R8
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFF_STAT && bus_wdata[NIN-1:0] == '1 &&
         rise_ev == '0 && fall_ev == '0) |=> (!irq && rise_flag == '0 && fall_flag == '0));
endmodule

bind gpio_edge_port gpio_edge_chk #(.NLINES(NLINES), .NOUT(NOUT)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq),
    .rise_ev(rise_ev), .fall_ev(fall_ev), .rise_flag(rise_flag),
    .fall_flag(fall_flag)
);

// File: tb/sim_gpio_edge_port.sv
// Self-checking bench: directed corners plus seeded random traffic.
module sim_gpio_edge_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out, pad_oe;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench model of programmed state
    logic [7:0] m_dir = 8'h0F, m_out = 8'h00, m_cfg = 8'h00;
    logic [3:0] m_r = '0, m_f = '0;

    always #10 clk = ~clk;

    gpio_edge_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    function automatic logic [3:0] exp_status();
        logic [3:0] s;
        for (int k = 0; k < 4; k++) begin
            case (m_cfg[2*k +: 2])
                2'b00: s[k] = 1'b0;
                2'b01: s[k] = m_f[k];
                2'b10: s[k] = m_r[k];
                default: s[k] = m_r[k] | m_f[k];
            endcase
        end
        return s;
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(bus_rdata, exp, req);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        case (a)
            3'd0: m_dir = d;
            3'd1: m_out = d;
            3'd3: m_cfg = d;
            3'd4: begin m_r &= ~d[3:0]; m_f &= ~d[3:0]; end
            default: ;
        endcase
    endtask

    task automatic pins(input logic [7:0] v);
        @(negedge clk);
        m_r |= v[7:4] & ~pad_in[7:4];
        m_f |= ~v[7:4] & pad_in[7:4];
        pad_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_all(input string req);
        rd(3'd0, m_dir, req);
        rd(3'd1, pad_in, req);
        rd(3'd3, m_cfg, req);
        rd(3'd4, {4'h0, exp_status()}, req);
        check({7'd0, irq}, {7'd0, |exp_status()}, req);
        check(pad_out, m_out, req);
        check(pad_oe, m_dir, req);
    endtask

    // watchdog: a hung run counts as a failure
    initial begin
        #4_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        check(pad_oe, 8'h0F, "R1");
        check(pad_out, 8'h00, "R1");
        check({7'd0, irq}, 8'h00, "R1");
        rd(3'd3, 8'h00, "R1");
        rd(3'd4, 8'h00, "R1");

        // R2 unused addresses
        wr(3'd2, 8'hFF); wr(3'd5, 8'hA5); wr(3'd7, 8'h3C);
        rd(3'd2, 8'h00, "R2"); rd(3'd6, 8'h00, "R2");
        check_all("R2");

        // R3 direction
        wr(3'd0, 8'hA5);
        check(pad_oe, 8'hA5, "R3");
        rd(3'd0, 8'hA5, "R3");

        // R4 latch vs pin levels and synchroniser latency
        wr(3'd1, 8'h5A);
        check(pad_out, 8'h5A, "R4");
        rd(3'd1, 8'h00, "R4");
        @(negedge clk); pad_in = 8'h03;
        @(negedge clk); bus_addr = 3'd1; #1; check(bus_rdata, 8'h00, "R4");
        @(negedge clk); #1; check(bus_rdata, 8'h03, "R4");
        m_dir = 8'hA5;

        // R11 low-line edges ignored
        wr(3'd3, 8'hFF);
        pins(8'h0C); pins(8'h00);
        check({7'd0, irq}, 8'h00, "R11");
        rd(3'd4, 8'h00, "R11");

        // R5/R6 codes: rise on input 0 visible under rise/any, not fall
        wr(3'd3, 8'h01);
        pins(8'h10);
        rd(3'd4, 8'h00, "R5");
        check({7'd0, irq}, 8'h00, "R5");
        // R10 hidden rising edge surfaces once selected
        wr(3'd3, 8'h02);
        rd(3'd4, 8'h01, "R10");
        check({7'd0, irq}, 8'h01, "R10");
        // R6 falling flag latched while rise selected
        pins(8'h00);
        wr(3'd3, 8'h01);
        rd(3'd4, 8'h01, "R6");
        // R8 clear both flags, then any-edge code shows nothing
        wr(3'd4, 8'h01);
        wr(3'd3, 8'h03);
        rd(3'd4, 8'h00, "R8");
        check({7'd0, irq}, 8'h00, "R8");
        // R8 writing zero leaves flags
        wr(3'd3, 8'hC0);
        pins(8'h80);
        wr(3'd4, 8'h07);
        rd(3'd4, 8'h08, "R8");
        check({7'd0, irq}, 8'h01, "R7");
        wr(3'd4, 8'h08);
        rd(3'd4, 8'h00, "R8");

        // R6 third-edge timing and R9 set beats clear
        wr(3'd3, 8'h08);
        @(negedge clk); pad_in = 8'hA0; m_r |= 4'b0010;
        @(negedge clk);
        @(negedge clk); bus_addr = 3'd4; bus_wdata = 8'h02; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
        rd(3'd4, 8'h02, "R9");
        check({7'd0, irq}, 8'h01, "R9");
        wr(3'd4, 8'h0F);
        check({7'd0, irq}, 8'h00, "R8");

        // constrained random traffic
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom_range(0, 5);
            case (op)
                0, 1: pins(8'($urandom));
                2: wr(3'd3, 8'($urandom));
                3: wr(3'd4, 8'($urandom));
                4: wr(3'd1, 8'($urandom));
                default: wr(3'd0, 8'($urandom));
            endcase
            check_all("R7");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule